// File: doc/BRIEF.md
# Cascaded Two-Bank Interrupt Controller

This block collects level-sensitive interrupt requests from two banks and presents them to a processor as a single level interrupt line. The primary bank has 40 sources. The secondary bank has 32 sources, and its combined request is folded into primary source 0. Each bank latches its requests into pending flags. Software acknowledges a request by writing ones to a clear register. It controls masking with separate set and clear strobes, so each bit is changed on its own and no read-modify-write is needed.

A read-only index register names the primary source to service: the lowest-numbered enabled pending source other than the cascade. When it reads zero, software acknowledges source 0 and scans the secondary status word, lowest bit first. A small register file holds a channel number for each primary source; after reset, each entry holds its own source number.

All access goes through a 32-bit single-cycle register bus. A write takes effect at the clock edge on which the write strobe is high. Read data is combinational from the address.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, every pending flag and every enable bit is 0, `cpu_irq` is 0, the index register reads 0, and channel entry n reads n.
- R2: On every clock edge, a high source input sets its pending flag whatever its enable is. Primary status is read at byte address 0x00 (sources 0..31, bit n = source n) and 0x04 (sources 32..39 in bits 7:0). Secondary status is read at 0x80.
- R3: A write to 0x10 or 0x14 clears each primary pending flag whose data bit is 1, and leaves flags under 0 bits unchanged. If the source input is high on that same edge, the flag stays set. A read of 0x10/0x14 returns the pending flags.
- R4: A write to 0x20/0x24 sets, and a write to 0x30/0x34, clears each primary enable bit whose data bit is 1; 0 bits and cycles without a write leave enables unchanged. Reads of these four addresses return the enable mask.
- R5: The secondary bank works the same way. Status and status-clear are at 0x80/0x88, enable-set and enable-clear at 0x90/0x98, with bit n = secondary source n.
- R6: The input of primary source 0 is the OR of the enabled pending secondary flags. It is latched into primary flag 0 on the next edge and can be re-latched after an acknowledge while that OR is still 1.
- R7: Address 0x40 returns, in bits 5:0, the lowest-numbered primary source in 1..39 that is both enabled and pending. It returns 0 when no such source exists, even if source 0 is enabled and pending.
- R8: `cpu_irq` is 1 in the same cycle as any primary source, including source 0, that is both enabled and pending.
- R9: Channel entry n is at 0x200 + 4n. It stores bits 5:0 of the written data and reads back zero-extended.
- R10: Primary word 1 bits 31:8, unaligned addresses and all unassigned addresses read 0. Writes to unassigned addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pri_src | input | 39 | Primary source levels 39..1 (source 0 is the cascade) |
| sec_src | input | 32 | Secondary source levels |
| cpu_irq | output | 1 | Level interrupt to the processor |

## Verification
Two functions can act on the same flag in one cycle: a status-clear write, and a source that is still high, or a cascade OR that is still active. The bench provokes this on purpose. It acknowledges a primary source while holding its input high, and it acknowledges primary 0 while an enabled secondary request is still pending. Random traffic also lets clear writes land on live sources. Each result is judged by reading the status word afterwards and comparing it with a bench model in which the set wins over the clear.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   // register group spacing for the primary bank
   localparam int unsigned GRP_STRIDE = 'h10;
   localparam int unsigned GRP_STAT   = 0;
   localparam int unsigned GRP_ACK    = 1;
   localparam int unsigned GRP_ESET   = 2;
   localparam int unsigned GRP_ECLR   = 3;
   // single-word registers
   localparam int unsigned IDX_ADDR   = 'h40;
   localparam int unsigned SEC_STAT   = 'h80;
   localparam int unsigned SEC_ACK    = 'h88;
   localparam int unsigned SEC_ESET   = 'h90;
   localparam int unsigned SEC_ECLR   = 'h98;
   localparam int unsigned MAP_BASE   = 'h200;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level,
   input  logic [N-1:0] ack_mask,
   input  logic [N-1:0] en_set,
   input  logic [N-1:0] en_clr,
   output logic [N-1:0] pend,
   output logic [N-1:0] en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         en   <= '0;
      end else begin
         // a live level wins over an acknowledge on the same edge
         pend <= (pend & ~ack_mask) | level;
         en   <= (en | en_set) & ~en_clr;
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N  = 40,
   parameter int unsigned IW = 6
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx
);
   // lowest set bit above bit 0 wins; bit 0 is never reported
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 1; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/irq_chan_map.sv
module irq_chan_map #(
   parameter int unsigned N  = 40,
   parameter int unsigned CW = 6,
   parameter int unsigned IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [IW-1:0] sel,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] rdata
);
   logic [CW-1:0] ent [N];

   for (genvar n = 0; n < N; n++) begin : g_ent
      logic [CW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                    q <= CW'(n);
         else if (wr && sel == IW'(n))  q <= wdata;
      end
      assign ent[n] = q;
   end

   assign rdata = (sel < IW'(N)) ? ent[sel] : '0;
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
   parameter int unsigned NUM_PRI = 40,
   parameter int unsigned NUM_SEC = 32,
   parameter int unsigned CHAN_W  = 6,
   parameter int unsigned AW      = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      bus_addr,
   input  logic               bus_wr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_PRI-1:1] pri_src,
   input  logic [NUM_SEC-1:0] sec_src,
   output logic               cpu_irq
);
   import irq_ctrl_pkg::*;

   localparam int unsigned IW  = $clog2(NUM_PRI);
   localparam int unsigned NPW = (NUM_PRI + 31) / 32;
   localparam int unsigned MAP_END = MAP_BASE + 4 * NUM_PRI;

   // elaboration-time parameter checks
   if (NUM_PRI < 2 || NUM_PRI > 128) begin : g_bad_pri
      $error("NUM_PRI must lie in 2..128");
   end
   if (NUM_SEC < 1 || NUM_SEC > 32) begin : g_bad_sec
      $error("NUM_SEC must lie in 1..32");
   end
   if (CHAN_W < IW || CHAN_W > 32) begin : g_bad_chan
      $error("CHAN_W must hold a source number and fit a word");
   end
   if ((2 ** AW) <= MAP_END || AW < 8) begin : g_bad_aw
      $error("AW too narrow for the register map");
   end

   // ---------------- write decode, primary bank
   logic [NUM_PRI-1:0] p_ack, p_set, p_clr;
   for (genvar b = 0; b < NUM_PRI; b++) begin : g_pdec
      localparam int unsigned WOFS = 4 * (b / 32);
      assign p_ack[b] = bus_wr && bus_addr == AW'(GRP_STRIDE * GRP_ACK  + WOFS) && bus_wdata[b % 32];
      assign p_set[b] = bus_wr && bus_addr == AW'(GRP_STRIDE * GRP_ESET + WOFS) && bus_wdata[b % 32];
      assign p_clr[b] = bus_wr && bus_addr == AW'(GRP_STRIDE * GRP_ECLR + WOFS) && bus_wdata[b % 32];
   end

   // ---------------- write decode, secondary bank
   logic [NUM_SEC-1:0] s_ack, s_set, s_clr;
   assign s_ack = (bus_wr && bus_addr == AW'(SEC_ACK))  ? bus_wdata[NUM_SEC-1:0] : '0;
   assign s_set = (bus_wr && bus_addr == AW'(SEC_ESET)) ? bus_wdata[NUM_SEC-1:0] : '0;
   assign s_clr = (bus_wr && bus_addr == AW'(SEC_ECLR)) ? bus_wdata[NUM_SEC-1:0] : '0;

   // ---------------- banks and cascade
   logic [NUM_SEC-1:0] s_pend, s_en;
   logic [NUM_PRI-1:0] p_pend, p_en, p_act;
   logic               cascade;

   irq_bank #(.N(NUM_SEC)) u_sec (
      .clk(clk), .rst_n(rst_n), .level(sec_src),
      .ack_mask(s_ack), .en_set(s_set), .en_clr(s_clr),
      .pend(s_pend), .en(s_en)
   );

   assign cascade = |(s_pend & s_en);

   irq_bank #(.N(NUM_PRI)) u_pri (
      .clk(clk), .rst_n(rst_n), .level({pri_src, cascade}),
      .ack_mask(p_ack), .en_set(p_set), .en_clr(p_clr),
      .pend(p_pend), .en(p_en)
   );

   assign p_act   = p_pend & p_en;
   assign cpu_irq = |p_act;

   logic [IW-1:0] p_idx;
   irq_prio_enc #(.N(NUM_PRI), .IW(IW)) u_prio (.req(p_act), .idx(p_idx));

   // ---------------- channel map
   logic              map_hit;
   logic [IW-1:0]     map_sel;
   logic [CHAN_W-1:0] map_rd;
   assign map_hit = bus_addr >= AW'(MAP_BASE) && bus_addr < AW'(MAP_END) && bus_addr[1:0] == 2'b00;
   assign map_sel = map_hit ? IW'((bus_addr - AW'(MAP_BASE)) >> 2) : IW'(NUM_PRI);

   irq_chan_map #(.N(NUM_PRI), .CW(CHAN_W), .IW(IW)) u_map (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr && map_hit), .sel(map_sel),
      .wdata(bus_wdata[CHAN_W-1:0]), .rdata(map_rd)
   );

   // ---------------- read mux
   logic [NPW*32-1:0] p_pend_pad, p_en_pad;
   assign p_pend_pad = (NPW * 32)'(p_pend);
   assign p_en_pad   = (NPW * 32)'(p_en);

   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < int'(NPW); w++) begin
         if (bus_addr == AW'(GRP_STRIDE * GRP_STAT + 4 * w) ||
             bus_addr == AW'(GRP_STRIDE * GRP_ACK  + 4 * w))
            bus_rdata = p_pend_pad[w*32 +: 32];
         if (bus_addr == AW'(GRP_STRIDE * GRP_ESET + 4 * w) ||
             bus_addr == AW'(GRP_STRIDE * GRP_ECLR + 4 * w))
            bus_rdata = p_en_pad[w*32 +: 32];
      end
      if (bus_addr == AW'(IDX_ADDR))                                bus_rdata = 32'(p_idx);
      if (bus_addr == AW'(SEC_STAT) || bus_addr == AW'(SEC_ACK))   bus_rdata = 32'(s_pend);
      if (bus_addr == AW'(SEC_ESET) || bus_addr == AW'(SEC_ECLR))  bus_rdata = 32'(s_en);
      if (map_hit)                                                  bus_rdata = 32'(map_rd);
   end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int unsigned NUM_PRI = 40,
   parameter int unsigned NUM_SEC = 32,
   parameter int unsigned AW      = 10,
   parameter int unsigned IW      = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [AW-1:0]      bus_addr,
   input logic               bus_wr,
   input logic [31:0]        bus_wdata,
   input logic [NUM_PRI-1:1] pri_src,
   input logic [NUM_SEC-1:0] sec_src,
   input logic [NUM_PRI-1:0] pri_pend,
   input logic [NUM_PRI-1:0] pri_en,
   input logic [NUM_SEC-1:0] sec_pend,
   input logic [NUM_SEC-1:0] sec_en,
   input logic [IW-1:0]      pri_idx,
   input logic               cpu_irq
);
   AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      pri_src[1] |=> pri_pend[1]); // R2

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'('h10) && bus_wdata[1] && !pri_src[1]) |=> !pri_pend[1]); // R3

   AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'('h20) && bus_wdata[1]) |=> pri_en[1]); // R4

   AST_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'('h30) && bus_wdata[1]) |=> !pri_en[1]); // R4

   AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pri_en) && $stable(sec_en))); // R4

   AST_SEC_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'('h88) && bus_wdata[0] && !sec_src[0]) |=> !sec_pend[0]); // R5

   AST_CASCADE_FEED: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sec_pend & sec_en)) |=> pri_pend[0]); // R6

   AST_INDEX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_idx != '0) |-> (pri_pend[pri_idx] && pri_en[pri_idx])); // R7

   AST_IRQ_WITH_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_idx != '0) |-> cpu_irq); // R8
endmodule

bind cascade_irq_ctrl irq_ctrl_chk #(
   .NUM_PRI(NUM_PRI), .NUM_SEC(NUM_SEC), .AW(AW), .IW(IW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .pri_src(pri_src), .sec_src(sec_src),
   .pri_pend(p_pend), .pri_en(p_en), .sec_pend(s_pend), .sec_en(s_en),
   .pri_idx(p_idx), .cpu_irq(cpu_irq)
);

// File: tb/test_cascade_irq_ctrl.sv
`timescale 1ns/1ps
module test_cascade_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [39:1] pri_src = '0;
   logic [31:0] sec_src = '0;
   logic        cpu_irq;

   always #10 clk = ~clk; // 50 MHz

   cascade_irq_ctrl i_cascade_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pri_src(pri_src),
      .sec_src(sec_src), .cpu_irq(cpu_irq)
   );

   int n_run  = 0;
   int n_fail = 0;

   // bench model of the register state
   logic [39:0] m_pp, m_pe;
   logic [31:0] m_sp, m_se;
   logic [5:0]  m_map [40];

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] exp_idx();
      logic [5:0] r = '0;
      for (int i = 39; i >= 1; i--) if (m_pp[i] && m_pe[i]) r = 6'(i);
      return r;
   endfunction

   function automatic logic [31:0] exp_read(input logic [9:0] a);
      case (a)
         10'h000, 10'h010: return m_pp[31:0];
         10'h004, 10'h014: return {24'h0, m_pp[39:32]};
         10'h020, 10'h030: return m_pe[31:0];
         10'h024, 10'h034: return {24'h0, m_pe[39:32]};
         10'h040:          return {26'h0, exp_idx()};
         10'h080, 10'h088: return m_sp;
         10'h090, 10'h098: return m_se;
         default: begin
            if (a >= 10'h200 && a < 10'h2A0 && a[1:0] == 2'b00)
               return {26'h0, m_map[(a - 10'h200) >> 2]};
            return 32'h0;
         end
      endcase
   endfunction

   function automatic string tag_of(input logic [9:0] a);
      if (a >= 10'h200) return "R9";
      if (a == 10'h040) return "R7";
      if (a >= 10'h080 && a <= 10'h098 && a[2:0] == 3'b000) return "R5";
      if (a >= 10'h020 && a <= 10'h034) return "R4";
      if (a <= 10'h014) return "R2";
      return "R10";
   endfunction

   // one clock cycle with an optional write; model advanced in step
   task automatic step(input logic wr, input logic [9:0] a, input logic [31:0] d);
      logic [39:0] pack, pset, pclr, lvl;
      logic [31:0] sack, sset, sclr;
      logic        casc;
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      pack = '0; pset = '0; pclr = '0; sack = '0; sset = '0; sclr = '0;
      if (wr) begin
         case (a)
            10'h010: pack = {8'h0, d};
            10'h014: pack = {d[7:0], 32'h0};
            10'h020: pset = {8'h0, d};
            10'h024: pset = {d[7:0], 32'h0};
            10'h030: pclr = {8'h0, d};
            10'h034: pclr = {d[7:0], 32'h0};
            10'h088: sack = d;
            10'h090: sset = d;
            10'h098: sclr = d;
            default: ;
         endcase
      end
      casc = |(m_sp & m_se);
      lvl  = {pri_src, casc};
      @(posedge clk);
      m_pp = (m_pp & ~pack) | lvl;
      m_pe = (m_pe | pset) & ~pclr;
      m_sp = (m_sp & ~sack) | sec_src;
      m_se = (m_se | sset) & ~sclr;
      if (wr && a >= 10'h200 && a < 10'h2A0 && a[1:0] == 2'b00)
         m_map[(a - 10'h200) >> 2] = d[5:0];
      @(negedge clk);
      #1;
      bus_wr = 1'b0;
      chk({31'h0, cpu_irq}, {31'h0, |(m_pp & m_pe)}, "R8 cpu_irq");
   endtask

   task automatic rd(input logic [9:0] a, input string tag);
      bus_wr = 1'b0; bus_addr = a;
      #1;
      chk(bus_rdata, exp_read(a), tag);
      step(1'b0, a, 32'h0);
   endtask

   task automatic clean();
      pri_src = '0; sec_src = '0;
      step(1'b1, 10'h030, 32'hFFFF_FFFF);
      step(1'b1, 10'h034, 32'hFFFF_FFFF);
      step(1'b1, 10'h098, 32'hFFFF_FFFF);
      step(1'b1, 10'h088, 32'hFFFF_FFFF);
      step(1'b1, 10'h010, 32'hFFFF_FFFF);
      step(1'b1, 10'h014, 32'hFFFF_FFFF);
   endtask

   localparam logic [9:0] REGS [12] = '{10'h010, 10'h014, 10'h020, 10'h024, 10'h030, 10'h034,
                                        10'h088, 10'h090, 10'h098, 10'h044, 10'h0A0, 10'h3FC};
   localparam logic [9:0] RDS [14] = '{10'h000, 10'h004, 10'h010, 10'h014, 10'h020, 10'h024,
                                       10'h034, 10'h040, 10'h080, 10'h090, 10'h098, 10'h044,
                                       10'h2A0, 10'h201};

   initial begin
      m_pp = '0; m_pe = '0; m_sp = '0; m_se = '0;
      for (int n = 0; n < 40; n++) m_map[n] = 6'(n);
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state observed while reset is held
      chk({31'h0, cpu_irq}, 32'h0, "R1 irq in reset");
      rst_n = 1'b1;
      @(negedge clk); #1;
      bus_addr = 10'h020; #1; chk(bus_rdata, 32'h0, "R1 enable after reset");
      bus_addr = 10'h000; #1; chk(bus_rdata, 32'h0, "R1 pending after reset");
      bus_addr = 10'h040; #1; chk(bus_rdata, 32'h0, "R1 index after reset");
      bus_addr = 10'h21C; #1; chk(bus_rdata, 32'd7, "R1 map entry 7");
      bus_addr = 10'h29C; #1; chk(bus_rdata, 32'd39, "R1 map entry 39");

      // R4 / R10: enable set and clear strobes
      step(1'b1, 10'h020, 32'h0000_0208);
      rd(10'h020, "R4 enable set");
      step(1'b1, 10'h030, 32'h0000_0008);
      rd(10'h030, "R4 enable clear one bit");
      step(1'b1, 10'h024, 32'hFFFF_FFFF);
      bus_addr = 10'h024; #1; chk(bus_rdata, 32'h0000_00FF, "R10 word1 upper bits");
      step(1'b1, 10'h034, 32'hFFFF_FFFF);

      // R2 / R3: latching and acknowledge against a live level
      pri_src[5] = 1'b1;
      step(1'b0, 10'h000, 32'h0);
      pri_src[5] = 1'b0;
      bus_addr = 10'h000; #1; chk(bus_rdata & 32'h20, 32'h20, "R2 source 5 latched");
      step(1'b1, 10'h010, 32'hFFFF_FFDF);
      rd(10'h000, "R3 zero bit leaves flag");
      pri_src[5] = 1'b1;
      step(1'b1, 10'h010, 32'h0000_0020);
      bus_addr = 10'h000; #1; chk(bus_rdata & 32'h20, 32'h20, "R3 live level beats ack");
      pri_src[5] = 1'b0;
      step(1'b1, 10'h010, 32'h0000_0020);
      bus_addr = 10'h000; #1; chk(bus_rdata & 32'h20, 32'h0, "R3 ack clears");

      // R7 / R8: priority index
      pri_src[12] = 1'b1; pri_src[9] = 1'b1; pri_src[35] = 1'b1;
      step(1'b1, 10'h024, 32'h0000_0008);
      pri_src = '0;
      bus_addr = 10'h040; #1; chk(bus_rdata, 32'd9, "R7 lowest enabled wins");
      step(1'b1, 10'h030, 32'h0000_0200);
      bus_addr = 10'h040; #1; chk(bus_rdata, 32'd35, "R7 upper word source");
      chk({31'h0, cpu_irq}, 32'h1, "R8 irq with source 35");
      clean();

      // R5 / R6: cascade through primary 0
      sec_src[4] = 1'b1;
      step(1'b1, 10'h090, 32'h0000_0010);
      sec_src[4] = 1'b0;
      rd(10'h080, "R5 secondary status");
      bus_addr = 10'h000; #1; chk(bus_rdata & 32'h1, 32'h1, "R6 cascade latched");
      chk({31'h0, cpu_irq}, 32'h0, "R8 cascade masked");
      step(1'b1, 10'h020, 32'h0000_0001);
      chk({31'h0, cpu_irq}, 32'h1, "R8 cascade enabled");
      bus_addr = 10'h040; #1; chk(bus_rdata, 32'h0, "R7 cascade only reads 0");
      step(1'b1, 10'h010, 32'h0000_0001);
      bus_addr = 10'h000; #1; chk(bus_rdata & 32'h1, 32'h1, "R6 ack while cascade live");
      step(1'b1, 10'h088, 32'h0000_0010);
      step(1'b1, 10'h010, 32'h0000_0001);
      bus_addr = 10'h000; #1; chk(bus_rdata & 32'h1, 32'h0, "R6 ack after secondary ack");
      clean();

      // R9 / R10: channel map and unassigned space
      step(1'b1, 10'h214, 32'hFFFF_FF2A);
      rd(10'h214, "R9 map write");
      step(1'b1, 10'h044, 32'hFFFF_FFFF);
      rd(10'h044, "R10 unassigned read");
      rd(10'h020, "R10 unassigned write no effect");

      // constrained random traffic
      void'($urandom(32'h1BAD_5EED));
      for (int it = 0; it < 2500; it++) begin
         logic [9:0] a;
         if ($urandom % 8 == 0) begin
            pri_src = 39'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            sec_src = $urandom & $urandom & $urandom;
         end
         case ($urandom % 5)
            0, 1: begin
               a = REGS[$urandom % 12];
               step(1'b1, a, $urandom & $urandom);
            end
            2: begin
               a = 10'h200 + 10'(4 * ($urandom % 40));
               step(1'b1, a, $urandom);
            end
            default: begin
               if ($urandom % 4 == 0) a = 10'h200 + 10'(4 * ($urandom % 40));
               else a = RDS[$urandom % 14];
               rd(a, tag_of(a));
            end
         endcase
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule